// File: doc/BRIEF.md
# Gate Enable and Leg Overlap Trip Guard

This block stands between a modulator that produces switch commands for a three-leg bridge and the gate drivers. Every leg has an upper and a lower switch command. Each command passes straight through combinational logic to its gate output while the protection enable is high. No clock stage sits in the forwarding path, so pulse widths and edge positions at the gates match the commands exactly.

The block also watches each leg for an overlap, meaning that the upper and lower commands are both high at once. A leg whose overlap is sampled on consecutive rising clock edges, up to a set count, trips the block. The trip forces all six gate outputs low and raises a registered fault flag. The trip stays set until a clear request is sampled while no leg overlaps. Dead time is produced upstream, so a correct modulator never overlaps a leg.

Top module: `pwm_gate_guard`

## Requirements
- R1: Each gate output (`gate_hi[k]`, `gate_lo[k]` for leg k = 0..2) equals its command input in the same cycle while `gate_en` is high and `fault` is low. The path is combinational, so an input change shows at the output before the next clock edge.
- R2: While `gate_en` is low, all six gate outputs are low in the same cycle, whatever the command inputs are.
- R3: Driving `gate_en` low, for any length of time, never sets `fault`.
- R4: If `cmd_hi[k]` and `cmd_lo[k]` are both high at two consecutive rising clock edges on the same leg k, `fault` is high right after the second of those edges. The overlap is counted whether `gate_en` is high or low.
- R5: An overlap sampled at only one rising edge does not set `fault`. The count is kept per leg, so an overlap on one leg followed at the next edge by an overlap on another leg does not set `fault` either.
- R6: While `fault` is high, all six gate outputs are low, whatever the command inputs and `gate_en` are.
- R7: Once set, `fault` stays high until a rising edge at which `trip_clr` is high and no leg has both commands high. That edge clears `fault`. A `trip_clr` sampled while some leg overlaps has no effect.
- R8: Synchronous active-high `rst` clears `fault` and every leg's overlap count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_en | input | 1 | Protection enable; low blocks every gate |
| trip_clr | input | 1 | Request to clear a latched trip |
| cmd_hi | input | 3 | Upper-switch command, one bit per leg |
| cmd_lo | input | 3 | Lower-switch command, one bit per leg |
| gate_hi | output | 3 | Gated upper-switch drive, one bit per leg |
| gate_lo | output | 3 | Gated lower-switch drive, one bit per leg |
| fault | output | 1 | Registered trip flag |

## Verification
The assertions assume that the command, enable and clear inputs are stable around each rising edge. Under that assumption the overlap seen at an edge is well defined, and the two-sample rule can be checked against a one-cycle history of the overlap vector kept in the checker. The bench changes every input just after a falling edge and samples one time unit after a change or a rising edge. This keeps every input away from the sampling edge. The bench also forces overlaps on purpose, both single-edge and sustained, to exercise the trip path the assertions watch.

// File: rtl/pwm_guard_pkg.sv
package pwm_guard_pkg;

    localparam int unsigned LEGS_DEF    = 3;
    localparam int unsigned CONFIRM_DEF = 2;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_cmd_t;

    function automatic logic leg_overlaps(input leg_cmd_t c);
        return c.hi & c.lo;
    endfunction

    function automatic leg_cmd_t leg_mask(input leg_cmd_t c, input logic pass);
        leg_cmd_t r;
        r.hi = c.hi & pass;
        r.lo = c.lo & pass;
        return r;
    endfunction

endpackage

// File: rtl/leg_overlap_filter.sv
module leg_overlap_filter
    import pwm_guard_pkg::*;
#(
    parameter int unsigned CONFIRM = CONFIRM_DEF
) (
    input  logic     clk,
    input  logic     rst,
    input  leg_cmd_t cmd,
    output logic     overlap,
    output logic     confirm
);
    localparam int unsigned CW = (CONFIRM > 2) ? $clog2(CONFIRM) : 1;
    localparam logic [CW-1:0] LAST = CW'(CONFIRM - 1);

    logic [CW-1:0] run_q;

    assign overlap = leg_overlaps(cmd);
    // this edge completes the run of CONFIRM overlapping samples
    assign confirm = overlap && (run_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !overlap) begin
            run_q <= '0;
        end else if (run_q != LAST) begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/trip_latch.sv
module trip_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    input  logic any_overlap,
    output logic trip
);
    logic trip_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            trip_q <= 1'b0;
        end else if (set_req) begin
            trip_q <= 1'b1;
        end else if (clr_req && !any_overlap) begin
            trip_q <= 1'b0;
        end
    end

    assign trip = trip_q;
endmodule

// File: rtl/gate_mask.sv
module gate_mask
    import pwm_guard_pkg::*;
#(
    parameter int unsigned NUM_LEGS = LEGS_DEF
) (
    input  leg_cmd_t [NUM_LEGS-1:0] cmd,
    input  logic                    enable,
    input  logic                    trip,
    output leg_cmd_t [NUM_LEGS-1:0] gate
);
    logic pass;
    assign pass = enable & ~trip;

    for (genvar k = 0; k < NUM_LEGS; k++) begin : g_leg
        assign gate[k] = leg_mask(cmd[k], pass);
    end
endmodule

// File: rtl/pwm_gate_guard.sv
module pwm_gate_guard
    import pwm_guard_pkg::*;
#(
    parameter int unsigned NUM_LEGS = LEGS_DEF,
    parameter int unsigned CONFIRM  = CONFIRM_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                gate_en,
    input  logic                trip_clr,
    input  logic [NUM_LEGS-1:0] cmd_hi,
    input  logic [NUM_LEGS-1:0] cmd_lo,
    output logic [NUM_LEGS-1:0] gate_hi,
    output logic [NUM_LEGS-1:0] gate_lo,
    output logic                fault
);
    leg_cmd_t [NUM_LEGS-1:0] legs;
    leg_cmd_t [NUM_LEGS-1:0] gated;
    logic     [NUM_LEGS-1:0] leg_ovl;
    logic     [NUM_LEGS-1:0] leg_cfm;
    logic                    trip;

    for (genvar k = 0; k < NUM_LEGS; k++) begin : g_leg
        assign legs[k].hi = cmd_hi[k];
        assign legs[k].lo = cmd_lo[k];

        leg_overlap_filter #(.CONFIRM(CONFIRM)) u_filt (
            .clk     (clk),
            .rst     (rst),
            .cmd     (legs[k]),
            .overlap (leg_ovl[k]),
            .confirm (leg_cfm[k])
        );

        assign gate_hi[k] = gated[k].hi;
        assign gate_lo[k] = gated[k].lo;
    end

    trip_latch u_trip (
        .clk         (clk),
        .rst         (rst),
        .set_req     (|leg_cfm),
        .clr_req     (trip_clr),
        .any_overlap (|leg_ovl),
        .trip        (trip)
    );

    gate_mask #(.NUM_LEGS(NUM_LEGS)) u_mask (
        .cmd    (legs),
        .enable (gate_en),
        .trip   (trip),
        .gate   (gated)
    );

    assign fault = trip;
endmodule

// File: rtl/pwm_gate_guard_chk.sv
module pwm_gate_guard_chk #(
    parameter int unsigned NUM_LEGS = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                gate_en,
    input logic                trip_clr,
    input logic [NUM_LEGS-1:0] cmd_hi,
    input logic [NUM_LEGS-1:0] cmd_lo,
    input logic [NUM_LEGS-1:0] gate_hi,
    input logic [NUM_LEGS-1:0] gate_lo,
    input logic                fault
);
    logic [NUM_LEGS-1:0] ovl;
    logic [NUM_LEGS-1:0] ovl_prev;

    assign ovl = cmd_hi & cmd_lo;

    always_ff @(posedge clk) begin
        if (rst) ovl_prev <= '0;
        else     ovl_prev <= ovl;
    end

    p_gate_follows_r1: assert property (@(posedge clk) disable iff (rst)
        (gate_en && !fault) |-> (gate_hi == cmd_hi && gate_lo == cmd_lo));

    p_enable_blocks_r2: assert property (@(posedge clk) disable iff (rst)
        !gate_en |-> (gate_hi == '0 && gate_lo == '0));

    p_no_spurious_trip_r5: assert property (@(posedge clk) disable iff (rst)
        (!fault && (ovl & ovl_prev) == '0) |=> !fault);

    p_trip_sets_r4: assert property (@(posedge clk) disable iff (rst)
        ((ovl & ovl_prev) != '0) |=> fault);

    p_fault_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        fault |-> (gate_hi == '0 && gate_lo == '0));

    p_fault_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (fault && (!trip_clr || ovl != '0)) |=> fault);

    p_fault_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (fault && trip_clr && ovl == '0) |=> !fault);

    p_reset_clears_r8: assert property (@(posedge clk)
        rst |=> !fault);
endmodule

bind pwm_gate_guard pwm_gate_guard_chk #(.NUM_LEGS(NUM_LEGS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .gate_en  (gate_en),
    .trip_clr (trip_clr),
    .cmd_hi   (cmd_hi),
    .cmd_lo   (cmd_lo),
    .gate_hi  (gate_hi),
    .gate_lo  (gate_lo),
    .fault    (fault)
);

// File: tb/pwm_gate_guard_bench.sv
module pwm_gate_guard_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       gate_en;
    logic       trip_clr;
    logic [2:0] cmd_hi;
    logic [2:0] cmd_lo;
    logic [2:0] gate_hi;
    logic [2:0] gate_lo;
    logic       fault;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    pwm_gate_guard u_pwm_gate_guard (
        .clk(clk), .rst(rst), .gate_en(gate_en), .trip_clr(trip_clr),
        .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .fault(fault)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edge_then_settle();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1; gate_en = 1; trip_clr = 0; cmd_hi = 3'b011; cmd_lo = 3'b011;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0; cmd_hi = 0; cmd_lo = 0;
        #1;
        chk("R8 fault after reset", {7'd0, fault}, 8'h00);
        edge_then_settle();
        // overlap seen during reset must not count toward a trip
        chk("R8 count cleared", {7'd0, fault}, 8'h00);
    endtask

    task automatic t_forward();
        @(negedge clk);
        cmd_hi = 3'b101; cmd_lo = 3'b010;
        #1;
        chk("R1 hi pattern A", {5'd0, gate_hi}, 8'h05);
        chk("R1 lo pattern A", {5'd0, gate_lo}, 8'h02);
        #1;
        cmd_hi = 3'b010; cmd_lo = 3'b101;
        #1;
        // changed mid-cycle, no clock edge in between
        chk("R1 hi pattern B", {5'd0, gate_hi}, 8'h02);
        chk("R1 lo pattern B", {5'd0, gate_lo}, 8'h05);
        @(negedge clk);
        cmd_hi = 0; cmd_lo = 0;
    endtask

    task automatic t_enable();
        @(negedge clk);
        cmd_hi = 3'b111; cmd_lo = 3'b000; gate_en = 0;
        #1;
        chk("R2 hi blocked", {5'd0, gate_hi}, 8'h00);
        cmd_hi = 3'b000; cmd_lo = 3'b111;
        #1;
        chk("R2 lo blocked", {5'd0, gate_lo}, 8'h00);
        repeat (4) edge_then_settle();
        chk("R3 enable low no fault", {7'd0, fault}, 8'h00);
        @(negedge clk);
        gate_en = 1;
        #1;
        chk("R2 lo restored", {5'd0, gate_lo}, 8'h07);
        @(negedge clk);
        cmd_lo = 0;
    endtask

    task automatic t_single_glitch();
        @(negedge clk);
        cmd_hi = 3'b010; cmd_lo = 3'b010;
        @(negedge clk);
        cmd_hi = 0; cmd_lo = 0;
        edge_then_settle();
        edge_then_settle();
        chk("R5 one-edge overlap", {7'd0, fault}, 8'h00);
    endtask

    task automatic t_cross_leg();
        @(negedge clk);
        cmd_hi = 3'b001; cmd_lo = 3'b001;
        @(negedge clk);
        cmd_hi = 3'b100; cmd_lo = 3'b100;
        @(negedge clk);
        cmd_hi = 0; cmd_lo = 0;
        edge_then_settle();
        chk("R5 overlap hops legs", {7'd0, fault}, 8'h00);
    endtask

    task automatic t_trip_and_clear();
        @(negedge clk);
        cmd_hi = 3'b001; cmd_lo = 3'b001;
        edge_then_settle();
        chk("R4 not yet after first edge", {7'd0, fault}, 8'h00);
        chk("R4 overlap still forwarded", {5'd0, gate_hi}, 8'h01);
        edge_then_settle();
        chk("R4 fault after second edge", {7'd0, fault}, 8'h01);
        chk("R6 hi forced low", {5'd0, gate_hi}, 8'h00);
        chk("R6 lo forced low", {5'd0, gate_lo}, 8'h00);
        @(negedge clk);
        trip_clr = 1;
        edge_then_settle();
        chk("R7 clear blocked by overlap", {7'd0, fault}, 8'h01);
        @(negedge clk);
        trip_clr = 0; cmd_hi = 3'b110; cmd_lo = 3'b001;
        repeat (3) edge_then_settle();
        chk("R7 fault holds without clear", {7'd0, fault}, 8'h01);
        chk("R6 clean commands blocked", {5'd0, gate_hi}, 8'h00);
        @(negedge clk);
        trip_clr = 1;
        edge_then_settle();
        chk("R7 clear accepted", {7'd0, fault}, 8'h00);
        chk("R1 forwarding resumes", {5'd0, gate_hi}, 8'h06);
        @(negedge clk);
        trip_clr = 0; cmd_hi = 0; cmd_lo = 0;
    endtask

    task automatic t_trip_while_disabled();
        @(negedge clk);
        gate_en = 0; cmd_hi = 3'b100; cmd_lo = 3'b100;
        edge_then_settle();
        edge_then_settle();
        chk("R4 trips with enable low", {7'd0, fault}, 8'h01);
        @(negedge clk);
        cmd_hi = 0; cmd_lo = 0; gate_en = 1; rst = 1;
        edge_then_settle();
        chk("R8 reset clears trip", {7'd0, fault}, 8'h00);
        @(negedge clk);
        rst = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_forward();
        t_enable();
        t_single_glitch();
        t_cross_leg();
        t_trip_and_clear();
        t_trip_while_disabled();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule